// File: doc/BRIEF.md
# MFM Write Precompensation Shifter

This block sits between a disk controller's serial write-data output and the drive's write-data input. It runs on a 16 MHz reference clock, so one clock cycle is 62.5 ns. Each write pulse from the controller is placed on that grid and delayed by a nominal amount. The controller's per-pulse early and late controls can make the delay shorter or longer by a programmable shift.

The nominal delay equals the largest shift the 3-bit code can ask for, which is 7 cycles. An early pulse is produced by subtracting the shift from the nominal delay. A late pulse adds the shift to it. Shifting happens only in double-density (MFM) mode; in single-density (FM) mode every pulse leaves at the nominal position.

The block also produces the controller's write clock by dividing the reference. It has no enable, so the clock runs from reset onward.

The pulse path is a three-state machine:
- IDLE waits for a leading edge on the input.
- HOLD counts down the latched delay.
- EMIT drives the output for a fixed width.

Its transitions:
- IDLE→HOLD on a sampled leading edge.
- HOLD→HOLD while the delay count is non-zero.
- HOLD→EMIT when the count reaches zero.
- EMIT→EMIT while the width count is non-zero.
- EMIT→IDLE when the width count reaches zero.

Top module: `wpc_shifter`

## Requirements
- R1: Let k be the first clock edge at which the input write data is sampled high after being sampled low. In MFM mode with neither early nor late asserted, the output pulse is first high after edge k+8. This is the nominal delay of 7 cycles.
- R2: In MFM mode with only early asserted, the delay is 7 minus the shift code, with one code step equal to one 62.5 ns cycle (code 4 gives 250 ns). The output is first high after edge k+1+delay.
- R3: In MFM mode with only late asserted, the delay is 7 plus the shift code. The output is first high after edge k+1+delay.
- R4: With early and late both asserted, the pulse uses the nominal delay of 7.
- R5: In FM mode (mfm_en low), the pulse uses the nominal delay of 7 whatever the early, late and code inputs are.
- R6: Every output pulse is high for exactly 2 consecutive cycles, whatever delay was applied.
- R7: Early, late, code and mfm_en are taken only at edge k. Changing them after edge k does not alter that pulse's position.
- R8: A leading edge sampled while a pulse is in HOLD or EMIT is ignored and produces no further output pulse.
- R9: The write clock has a period of 32 cycles (500 kHz) and is high for exactly 4 cycles (250 ns) of each period. It runs continuously, unaffected by write traffic.
- R10: While reset is asserted, both the write-data output and the write clock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data_in | input | 1 | Serial write pulses from the controller |
| early_in | input | 1 | Request to shift the current pulse earlier |
| late_in | input | 1 | Request to shift the current pulse later |
| mfm_en | input | 1 | High selects MFM (shifting on), low selects FM |
| shift_code | input | 3 | Shift amount in 62.5 ns steps |
| wr_data_out | output | 1 | Precompensated write pulses to the drive |
| wr_clk_out | output | 1 | 500 kHz write clock to the controller |

## Verification
A wrong delay latched in HOLD shows at the output as a pulse edge that is off by whole cycles. It is visible within 16 cycles of the input edge, so sweeping every mode and code against the arithmetic delay exposes it at once. A width count or state that is stuck shows as a pulse of the wrong length, or as a missing or extra pulse, within the same window. A wrong divider count shows as a wrong high or low run of the write clock within one 32-cycle period.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_EMIT = 2'd2
    } wpc_state_e;
endpackage

// File: rtl/wpc_delay_sel.sv
module wpc_delay_sel #(
    parameter int SHIFT_W = 3
) (
    input  logic               mfm_en,
    input  logic               early,
    input  logic               late,
    input  logic [SHIFT_W-1:0] code,
    output logic [SHIFT_W:0]   delay_o
);
    localparam int DW = SHIFT_W + 1;
    localparam logic [DW-1:0] NOMINAL = DW'((1 << SHIFT_W) - 1);

    logic [DW-1:0] step;
    assign step = {1'b0, code};

    always_comb begin
        delay_o = NOMINAL;
        if (mfm_en && early && !late) begin
            delay_o = NOMINAL - step;
        end else if (mfm_en && late && !early) begin
            delay_o = NOMINAL + step;
        end
    end
endmodule

// File: rtl/wpc_pulse_fsm.sv
module wpc_pulse_fsm
    import wpc_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int PULSE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [CNT_W-1:0] delay,
    output logic             pulse_o,
    output logic             idle_o
);
    localparam logic [CNT_W-1:0] WIDTH_LAST = CNT_W'(PULSE_W - 1);

    wpc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    state_d = ST_HOLD;
                    cnt_d   = delay;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ST_EMIT;
                    cnt_d   = WIDTH_LAST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_EMIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pulse_o = (state_q == ST_EMIT);
        idle_o  = (state_q == ST_IDLE);
    end

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R8
    AST_PULSE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |=> pulse_o); // R6
    AST_EMIT_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(state_q) == ST_HOLD); // R8
endmodule

// File: rtl/wpc_wclk_gen.sv
module wpc_wclk_gen #(
    parameter int DIV = 32,
    parameter int HI  = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic wclk_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HI_C = CW'(HI);

    logic [CW-1:0] cnt_q;
    logic          wclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wclk_q <= 1'b0;
        end else begin
            wclk_q <= (cnt_q < HI_C);
            cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign wclk_o = wclk_q;

    AST_WCLK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wclk_q) |-> (cnt_q == CW'(1))); // R9
endmodule

// File: rtl/wpc_shifter.sv
module wpc_shifter
    import wpc_pkg::*;
#(
    parameter int SHIFT_W  = 3,
    parameter int PULSE_W  = 2,
    parameter int WCLK_DIV = 32,
    parameter int WCLK_HI  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_data_in,
    input  logic               early_in,
    input  logic               late_in,
    input  logic               mfm_en,
    input  logic [SHIFT_W-1:0] shift_code,
    output logic               wr_data_out,
    output logic               wr_clk_out
);
    localparam int DW    = SHIFT_W + 1;
    localparam int CNT_W = (DW > $clog2(PULSE_W + 1)) ? DW : $clog2(PULSE_W + 1);
    localparam logic [DW-1:0] NOMINAL = DW'((1 << SHIFT_W) - 1);

    logic          din_q;
    logic          rise;
    logic          idle;
    logic [DW-1:0] delay;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= 1'b0;
        end else begin
            din_q <= wr_data_in;
        end
    end

    assign rise = wr_data_in && !din_q;

    wpc_delay_sel #(.SHIFT_W(SHIFT_W)) u_sel (
        .mfm_en  (mfm_en),
        .early   (early_in),
        .late    (late_in),
        .code    (shift_code),
        .delay_o (delay)
    );

    wpc_pulse_fsm #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (rise),
        .delay   (CNT_W'(delay)),
        .pulse_o (wr_data_out),
        .idle_o  (idle)
    );

    wpc_wclk_gen #(.DIV(WCLK_DIV), .HI(WCLK_HI)) u_wclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .wclk_o (wr_clk_out)
    );

    AST_FM_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && idle && !mfm_en) |-> (delay == NOMINAL)); // R5
    AST_BOTH_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && idle && early_in && late_in) |-> (delay == NOMINAL)); // R4
    AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && idle) |-> (delay <= DW'(2 * ((1 << SHIFT_W) - 1)))); // R3
endmodule

// File: tb/wpc_shifter_tb.sv
module wpc_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_data_in = 1'b0;
    logic       early_in = 1'b0;
    logic       late_in = 1'b0;
    logic       mfm_en = 1'b0;
    logic [2:0] shift_code = 3'd0;
    logic       wr_data_out;
    logic       wr_clk_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wpc_shifter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data_in  (wr_data_in),
        .early_in    (early_in),
        .late_in     (late_in),
        .mfm_en      (mfm_en),
        .shift_code  (shift_code),
        .wr_data_out (wr_data_out),
        .wr_clk_out  (wr_clk_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One pulse: inputs set at a negedge, outputs observed at 40 later negedges.
    // The first high observation index is delay+2; the count of highs is the width.
    // Modes: 1 swaps the controls to early/code 7 at index 1, 2 re-triggers while busy.
    task automatic run_pulse(input bit m, input bit e, input bit l, input int code,
                             input int mode, output int first, output int width);
        first = -1;
        width = 0;
        @(negedge clk);
        mfm_en = m; early_in = e; late_in = l; shift_code = 3'(code);
        wr_data_in = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (wr_data_out) begin
                if (first < 0) first = i;
                width++;
            end
            if (i == 1 && mode == 1) begin
                early_in = 1'b1; late_in = 1'b0; shift_code = 3'd7; mfm_en = 1'b1;
            end
            if (i == 3) wr_data_in = 1'b0;
            if (i == 5 && mode == 2) wr_data_in = 1'b1;
            if (i == 7 && mode == 2) wr_data_in = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int first, width, exp_d, hi_run, lo_run;
        string tag;
        repeat (4) @(negedge clk);
        check("R10 data_out in reset", int'(wr_data_out), 0);
        check("R10 wr_clk in reset", int'(wr_clk_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep of mode, early, late and code
        for (int m = 0; m < 2; m++) begin
            for (int el = 0; el < 4; el++) begin
                for (int c = 0; c < 8; c++) begin
                    bit e, l;
                    e = el[1];
                    l = el[0];
                    exp_d = 7;
                    if (m == 0) tag = "R5 FM nominal";
                    else if (e && l) tag = "R4 both nominal";
                    else if (e) begin tag = "R2 early"; exp_d = 7 - c; end
                    else if (l) begin tag = "R3 late"; exp_d = 7 + c; end
                    else tag = "R1 nominal";
                    run_pulse(m[0], e, l, c, 0, first, width);
                    check(tag, first, exp_d + 2);
                    check("R6 width", width, 2);
                end
            end
        end

        // R7: controls changed after the sampling edge have no effect
        run_pulse(1'b1, 1'b0, 1'b1, 5, 1, first, width);
        check("R7 late 5 held", first, 12 + 2);
        check("R7 width", width, 2);
        run_pulse(1'b0, 1'b0, 1'b0, 0, 1, first, width);
        check("R7 fm held", first, 7 + 2);

        // R8: a second edge while busy is ignored
        run_pulse(1'b1, 1'b0, 1'b0, 0, 2, first, width);
        check("R8 first pulse", first, 9);
        check("R8 no extra pulse", width, 2);
        run_pulse(1'b1, 1'b0, 1'b1, 7, 2, first, width);
        check("R8 late busy", first, 16);
        check("R8 late no extra", width, 2);

        // R9: write clock high/low run lengths, twice
        for (int rep = 0; rep < 2; rep++) begin
            hi_run = 0;
            lo_run = 0;
            while (wr_clk_out) @(negedge clk);
            while (!wr_clk_out) @(negedge clk);
            while (wr_clk_out) begin hi_run++; @(negedge clk); end
            while (!wr_clk_out) begin lo_run++; @(negedge clk); end
            check("R9 wclk high cycles", hi_run, 4);
            check("R9 wclk low cycles", lo_run, 28);
        end

        // R10: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 wr_clk after reset", int'(wr_clk_out), 0);
        check("R10 data_out after reset", int'(wr_data_out), 0);
        finish_run();
    end
endmodule